// File: doc/BRIEF.md
# Channel Status Buffer Transfer Controller

This block keeps three generations of per-block side-channel data for a two-channel digital audio link. Each generation holds channel status bytes and user data bytes for channel A and channel B. The capture stage is filled byte by byte by the stream deserializer. The host stage is the one software reads and edits. The transmit stage feeds the outgoing serializer.

On every block-start strobe the controller advances the data. Host stage contents move to the transmit stage, and capture stage contents move to the host stage. Both moves happen on the same clock edge, and the transmit stage receives the host contents from before that edge. For channel status only, configuration inputs can hold back either move independently. They can also shield the leading bytes of the host stage from being refreshed.

A byte-wide host port sees a window onto the host stage. The window shows either the channel status bytes or the user bytes. It can address one channel at a time, or both channels interleaved. A status byte output shows byte 0 of the host-stage channel status for the selected channel.

Top module: `cstx_xfer_ctrl`

## Requirements
- R1: After reset every byte of all three stages is 0, so `host_rdata`, `tx_byte` and `stat_byte` all read 0.
- R2: A capture write (`din_we`) stores `din_byte` at `din_kind` (0 = channel status, 1 = user), `din_chan` (0 = A, 1 = B) and `din_idx`. On `blk_start` with every hold input low, all `NBYTES` host-stage bytes of both kinds take the capture values. The new values are readable on the next cycle.
- R3: While `cfg_hold_de` is 1, `blk_start` leaves the host-stage channel status bytes of both channels unchanged.
- R4: While `cfg_hold_ef` is 1, `blk_start` leaves the transmit-stage channel status bytes of both channels unchanged.
- R5: While `cfg_keep_head` is 1, `blk_start` refreshes only channel status bytes `PROTECT_BYTES` and above (byte 5 and above by default). Lower bytes keep their host-stage value.
- R6: On `blk_start` the transmit stage takes the host-stage contents from before that same edge. `tx_byte` shows transmit byte `tx_idx` of kind `tx_kind` and channel `tx_chan`, and reads 0 when `tx_idx >= NBYTES`.
- R7: User bytes move on every `blk_start` in both directions, regardless of `cfg_hold_de`, `cfg_hold_ef` and `cfg_keep_head`.
- R8: `cfg_win_user` = 0 points host reads and writes at the channel status bytes of the host stage. `cfg_win_user` = 1 points them at the user bytes.
- R9: With `cfg_pair_mode` = 0, `host_addr` N below `NBYTES` maps to byte N of channel `cfg_chan_b`. Higher addresses read 0 and host writes to them are ignored.
- R10: With `cfg_pair_mode` = 1, address 2N maps to channel A byte N and address 2N+1 maps to channel B byte N. Addresses of `2*NBYTES` and above read 0 and host writes to them are ignored.
- R11: A host write on the same cycle as a `blk_start` copy wins for the byte it targets. All other bytes take the copied values.
- R12: `stat_byte` equals host-stage channel status byte 0 of channel `cfg_chan_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_user | input | 1 | Host window: 0 channel status, 1 user data |
| cfg_keep_head | input | 1 | Shield leading channel status bytes of the host stage |
| cfg_hold_de | input | 1 | Hold channel status capture-to-host copy |
| cfg_hold_ef | input | 1 | Hold channel status host-to-transmit copy |
| cfg_pair_mode | input | 1 | 0 single-channel window, 1 interleaved A/B window |
| cfg_chan_b | input | 1 | Channel select: 0 A, 1 B |
| blk_start | input | 1 | Block boundary strobe |
| din_we | input | 1 | Capture stage byte write |
| din_kind | input | 1 | Capture write kind: 0 status, 1 user |
| din_chan | input | 1 | Capture write channel |
| din_idx | input | IW | Capture write byte index |
| din_byte | input | 8 | Capture write data |
| host_we | input | 1 | Host byte write |
| host_addr | input | AW | Host window address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| tx_kind | input | 1 | Transmit read kind |
| tx_chan | input | 1 | Transmit read channel |
| tx_idx | input | IW | Transmit read byte index |
| tx_byte | output | 8 | Transmit read data |
| stat_byte | output | 8 | Selected channel status byte 0 |

IW = $clog2(NBYTES), AW = IW + 1.

## Verification
The bench uses the defaults, `NBYTES` = 24 and `PROTECT_BYTES` = 5. This gives a 6-bit host address. In single-channel mode, addresses 24 to 63 are out of range. In interleaved mode, addresses 48 to 63 are out of range. That lets the bench show that out-of-range reads return 0 and out-of-range writes are dropped in both modes. A shield of five bytes inside a 24-byte block lets one transfer show both shielded and refreshed bytes. A random phase then mixes strobes, hold inputs and host writes. This exercises host writes that land on a strobe cycle and holds that change between strobes.

// File: rtl/cstx_pkg.sv
package cstx_pkg;
   typedef enum logic {
      KIND_STATUS = 1'b0,
      KIND_USER   = 1'b1
   } cstx_kind_e;

   typedef enum logic {
      CHAN_A = 1'b0,
      CHAN_B = 1'b1
   } cstx_chan_e;

   localparam int CSTX_BYTE_W = 8;
   localparam int CSTX_KINDS  = 2;
   localparam int CSTX_CHANS  = 2;
endpackage

// File: rtl/cstx_stage.sv
module cstx_stage
   import cstx_pkg::*;
#(
   parameter  int NBYTES = 24,
   localparam int IW     = $clog2(NBYTES)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 load_en,
   input  logic [NBYTES-1:0]                    load_keep,
   input  logic [NBYTES-1:0][CSTX_BYTE_W-1:0]   load_data,
   input  logic                                 wr_en,
   input  logic [IW-1:0]                        wr_idx,
   input  logic [CSTX_BYTE_W-1:0]               wr_data,
   output logic [NBYTES-1:0][CSTX_BYTE_W-1:0]   q
);

   if (NBYTES < 2) begin : g_bad_depth
      $error("cstx_stage: NBYTES must be at least 2");
   end

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      logic hit;
      assign hit = wr_en && (wr_idx == IW'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q[i] <= '0;
         end else if (hit) begin
            q[i] <= wr_data;
         end else if (load_en && !load_keep[i]) begin
            q[i] <= load_data[i];
         end
      end
   end

   // R11: a byte write beats a concurrent bulk load for its byte
   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> q[$past(wr_idx)] == $past(wr_data));

   // R3 R4 R5: without load or write the stage holds
   a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !wr_en) |=> $stable(q));

endmodule

// File: rtl/cstx_host_map.sv
module cstx_host_map #(
   parameter  int NBYTES = 24,
   localparam int IW     = $clog2(NBYTES),
   localparam int AW     = IW + 1
) (
   input  logic          pair_mode,
   input  logic          chan_b,
   input  logic [AW-1:0] addr,
   output logic          ok,
   output logic [IW-1:0] idx,
   output logic          chan
);

   always_comb begin
      if (pair_mode) begin
         ok   = int'(addr) < 2 * NBYTES;
         idx  = addr[AW-1:1];
         chan = addr[0];
      end else begin
         ok   = int'(addr) < NBYTES;
         idx  = addr[IW-1:0];
         chan = chan_b;
      end
   end

endmodule

// File: rtl/cstx_xfer_ctrl.sv
module cstx_xfer_ctrl
   import cstx_pkg::*;
#(
   parameter  int NBYTES        = 24,
   parameter  int PROTECT_BYTES = 5,
   localparam int IW            = $clog2(NBYTES),
   localparam int AW            = IW + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_win_user,
   input  logic                   cfg_keep_head,
   input  logic                   cfg_hold_de,
   input  logic                   cfg_hold_ef,
   input  logic                   cfg_pair_mode,
   input  logic                   cfg_chan_b,
   input  logic                   blk_start,
   input  logic                   din_we,
   input  logic                   din_kind,
   input  logic                   din_chan,
   input  logic [IW-1:0]          din_idx,
   input  logic [CSTX_BYTE_W-1:0] din_byte,
   input  logic                   host_we,
   input  logic [AW-1:0]          host_addr,
   input  logic [CSTX_BYTE_W-1:0] host_wdata,
   output logic [CSTX_BYTE_W-1:0] host_rdata,
   input  logic                   tx_kind,
   input  logic                   tx_chan,
   input  logic [IW-1:0]          tx_idx,
   output logic [CSTX_BYTE_W-1:0] tx_byte,
   output logic [CSTX_BYTE_W-1:0] stat_byte
);

   if (PROTECT_BYTES < 0 || PROTECT_BYTES > NBYTES) begin : g_bad_protect
      $error("cstx_xfer_ctrl: PROTECT_BYTES must lie in 0..NBYTES");
   end

   logic [NBYTES-1:0][CSTX_BYTE_W-1:0] d_q [CSTX_KINDS][CSTX_CHANS];
   logic [NBYTES-1:0][CSTX_BYTE_W-1:0] e_q [CSTX_KINDS][CSTX_CHANS];
   logic [NBYTES-1:0][CSTX_BYTE_W-1:0] f_q [CSTX_KINDS][CSTX_CHANS];

   logic          h_ok;
   logic [IW-1:0] h_idx;
   logic          h_chan;

   cstx_host_map #(.NBYTES(NBYTES)) u_map (
      .pair_mode (cfg_pair_mode),
      .chan_b    (cfg_chan_b),
      .addr      (host_addr),
      .ok        (h_ok),
      .idx       (h_idx),
      .chan      (h_chan)
   );

   // shield mask for the leading channel status bytes
   logic [NBYTES-1:0] head_mask;
   for (genvar i = 0; i < NBYTES; i++) begin : g_mask
      if (i < PROTECT_BYTES) begin : g_in
         assign head_mask[i] = cfg_keep_head;
      end else begin : g_out
         assign head_mask[i] = 1'b0;
      end
   end

   for (genvar k = 0; k < CSTX_KINDS; k++) begin : g_kind
      logic              de_go;
      logic              ef_go;
      logic [NBYTES-1:0] de_keep;

      if (k == int'(KIND_STATUS)) begin : g_status
         assign de_go   = blk_start && !cfg_hold_de;
         assign ef_go   = blk_start && !cfg_hold_ef;
         assign de_keep = head_mask;
      end else begin : g_user
         assign de_go   = blk_start;
         assign ef_go   = blk_start;
         assign de_keep = '0;
      end

      for (genvar c = 0; c < CSTX_CHANS; c++) begin : g_chan
         logic d_wr;
         logic e_wr;

         assign d_wr = din_we && (din_kind == 1'(k)) && (din_chan == 1'(c));
         assign e_wr = host_we && h_ok && (cfg_win_user == 1'(k)) && (h_chan == 1'(c));

         cstx_stage #(.NBYTES(NBYTES)) u_d (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (1'b0),
            .load_keep ('0),
            .load_data ('0),
            .wr_en     (d_wr),
            .wr_idx    (din_idx),
            .wr_data   (din_byte),
            .q         (d_q[k][c])
         );

         cstx_stage #(.NBYTES(NBYTES)) u_e (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (de_go),
            .load_keep (de_keep),
            .load_data (d_q[k][c]),
            .wr_en     (e_wr),
            .wr_idx    (h_idx),
            .wr_data   (host_wdata),
            .q         (e_q[k][c])
         );

         cstx_stage #(.NBYTES(NBYTES)) u_f (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (ef_go),
            .load_keep ('0),
            .load_data (e_q[k][c]),
            .wr_en     (1'b0),
            .wr_idx    ('0),
            .wr_data   ('0),
            .q         (f_q[k][c])
         );

         // R6: transmit stage takes the pre-edge host contents
         a_r6_ef_old_copy: assert property (@(posedge clk) disable iff (!rst_n)
            ef_go |=> f_q[k][c] == $past(e_q[k][c]));
      end
   end

   always_comb begin
      host_rdata = '0;
      if (h_ok) host_rdata = e_q[cfg_win_user][h_chan][h_idx];
   end

   always_comb begin
      tx_byte = '0;
      if (int'(tx_idx) < NBYTES) tx_byte = f_q[tx_kind][tx_chan][tx_idx];
   end

   assign stat_byte = e_q[KIND_STATUS][cfg_chan_b][0];

   // R3: held capture-to-host copy leaves host status bytes alone
   a_r3_hold_de: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_start && cfg_hold_de && !host_we) |=>
         ($stable(e_q[0][0]) && $stable(e_q[0][1])));

   // R4: held host-to-transmit copy leaves transmit status bytes alone
   a_r4_hold_ef: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_start && cfg_hold_ef) |=>
         ($stable(f_q[0][0]) && $stable(f_q[0][1])));

   // R5: shielded leading bytes survive a transfer
   a_r5_keep_head: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_start && cfg_keep_head && !host_we) |=>
         ($stable(e_q[0][0][0]) && $stable(e_q[0][1][0])));

   // R7: user bytes always advance
   a_r7_user_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_start && !host_we) |=>
         (e_q[1][0] == $past(d_q[1][0]) && e_q[1][1] == $past(d_q[1][1])));

   // R9 R10: decoded index stays inside the buffer
   a_r9_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      h_ok |-> int'(h_idx) < NBYTES);

endmodule

// File: tb/test_cstx_xfer_ctrl.sv
`timescale 1ns/1ps
module test_cstx_xfer_ctrl;
   localparam int N  = 24;
   localparam int IW = $clog2(N);
   localparam int AW = IW + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_win_user = 0, cfg_keep_head = 0, cfg_hold_de = 0, cfg_hold_ef = 0;
   logic cfg_pair_mode = 0, cfg_chan_b = 0, blk_start = 0;
   logic din_we = 0, din_kind = 0, din_chan = 0;
   logic [IW-1:0] din_idx = '0;
   logic [7:0] din_byte = '0;
   logic host_we = 0;
   logic [AW-1:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic tx_kind = 0, tx_chan = 0;
   logic [IW-1:0] tx_idx = '0;
   logic [7:0] tx_byte, stat_byte;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2.5 clk = ~clk;

   cstx_xfer_ctrl i_cstx_xfer_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_win_user(cfg_win_user), .cfg_keep_head(cfg_keep_head),
      .cfg_hold_de(cfg_hold_de), .cfg_hold_ef(cfg_hold_ef),
      .cfg_pair_mode(cfg_pair_mode), .cfg_chan_b(cfg_chan_b),
      .blk_start(blk_start),
      .din_we(din_we), .din_kind(din_kind), .din_chan(din_chan),
      .din_idx(din_idx), .din_byte(din_byte),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata),
      .tx_kind(tx_kind), .tx_chan(tx_chan), .tx_idx(tx_idx), .tx_byte(tx_byte),
      .stat_byte(stat_byte)
   );

   // reference model: [kind][chan][byte]
   logic [7:0] md [2][2][N];
   logic [7:0] me [2][2][N];
   logic [7:0] mf [2][2][N];

   task automatic model_clear();
      for (int k = 0; k < 2; k++)
         for (int c = 0; c < 2; c++)
            for (int i = 0; i < N; i++) begin
               md[k][c][i] = 0; me[k][c][i] = 0; mf[k][c][i] = 0;
            end
   endtask

   function automatic void hmap(input int a, output bit ok, output int idx, output int ch);
      if (cfg_pair_mode) begin
         ok = a < 2 * N; idx = a / 2; ch = a % 2;
      end else begin
         ok = a < N; idx = a; ch = int'(cfg_chan_b);
      end
   endfunction

   task automatic model_clock();
      logic [7:0] nd [2][2][N];
      logic [7:0] ne [2][2][N];
      logic [7:0] nf [2][2][N];
      bit ok; int idx; int ch;
      nd = md; ne = me; nf = mf;
      if (din_we && int'(din_idx) < N) nd[din_kind][din_chan][din_idx] = din_byte;
      if (blk_start)
         for (int k = 0; k < 2; k++)
            for (int c = 0; c < 2; c++)
               for (int i = 0; i < N; i++) begin
                  if (k == 1 || !cfg_hold_ef) nf[k][c][i] = me[k][c][i];
                  if (k == 1 || (!cfg_hold_de && !(cfg_keep_head && i < 5)))
                     ne[k][c][i] = md[k][c][i];
               end
      hmap(int'(host_addr), ok, idx, ch);
      if (host_we && ok) ne[cfg_win_user][ch][idx] = host_wdata;
      md = nd; me = ne; mf = nf;
   endtask

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic compare_all();
      bit ok; int idx; int ch;
      logic [7:0] eh;
      hmap(int'(host_addr), ok, idx, ch);
      eh = ok ? me[cfg_win_user][ch][idx] : 8'h00;
      chk(cfg_pair_mode ? "R10 host read" : "R9 host read", host_rdata, eh);
      chk("R6 tx read", tx_byte, (int'(tx_idx) < N) ? mf[tx_kind][tx_chan][tx_idx] : 8'h00);
      chk("R12 status", stat_byte, me[0][cfg_chan_b][0]);
   endtask

   task automatic step();
      @(posedge clk);
      model_clock();
      @(negedge clk);
      compare_all();
   endtask

   task automatic dwrite(input bit k, input bit c, input int i, input logic [7:0] v);
      din_we = 1; din_kind = k; din_chan = c; din_idx = IW'(i); din_byte = v;
      step();
      din_we = 0;
   endtask

   task automatic strobe();
      blk_start = 1; step(); blk_start = 0;
   endtask

   task automatic peek(input int a, input logic [7:0] exp, input string tag);
      host_addr = AW'(a); #1; chk(tag, host_rdata, exp);
   endtask

   task automatic peek_tx(input bit k, input bit c, input int i, input logic [7:0] exp, input string tag);
      tx_kind = k; tx_chan = c; tx_idx = IW'(i); #1; chk(tag, tx_byte, exp);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1 reset state
      peek(0, 8'h00, "R1 host");
      peek_tx(0, 0, 0, 8'h00, "R1 tx");
      chk("R1 status", stat_byte, 8'h00);
      step();

      for (int i = 0; i < N; i++) begin
         dwrite(0, 0, i, 8'(8'h10 + i));
         dwrite(0, 1, i, 8'(8'h80 + i));
         dwrite(1, 0, i, 8'(8'h40 + i));
         dwrite(1, 1, i, 8'(8'hC0 + i));
      end
      strobe();
      peek(7, 8'h17, "R2 copy to host");
      peek_tx(0, 0, 7, 8'h00, "R6 tx holds old host");
      strobe();
      peek_tx(0, 0, 7, 8'h17, "R6 tx after second strobe");

      cfg_win_user = 1;
      peek(3, 8'h43, "R8 user window");
      cfg_pair_mode = 1;
      peek(7, 8'hC3, "R10 odd addr chan B");
      peek(6, 8'h43, "R10 even addr chan A");
      peek(50, 8'h00, "R10 out of range");
      cfg_pair_mode = 0; cfg_win_user = 0;
      cfg_chan_b = 1; #1;
      chk("R12 status chan B", stat_byte, 8'h80);
      peek(2, 8'h82, "R9 single mode chan B");
      cfg_chan_b = 0;
      peek(30, 8'h00, "R9 out of range");
      step();

      for (int i = 0; i < N; i++) dwrite(0, 0, i, 8'(8'h20 + i));
      cfg_keep_head = 1;
      strobe();
      peek(2, 8'h12, "R5 shielded byte");
      peek(9, 8'h29, "R5 refreshed byte");
      cfg_keep_head = 0;

      cfg_hold_de = 1;
      dwrite(0, 0, 9, 8'h55);
      dwrite(1, 0, 1, 8'h77);
      strobe();
      peek(9, 8'h29, "R3 held status");
      cfg_win_user = 1;
      peek(1, 8'h77, "R7 user passes hold");
      cfg_win_user = 0;

      cfg_hold_ef = 1;
      host_we = 1; host_addr = AW'(9); host_wdata = 8'h99;
      step();
      host_we = 0;
      strobe();
      peek_tx(0, 0, 9, 8'h29, "R4 tx status held");
      peek_tx(1, 0, 1, 8'h77, "R7 user reaches tx");
      peek(9, 8'h99, "R8 host write status");
      cfg_hold_ef = 0; cfg_hold_de = 0;

      host_we = 1; host_addr = AW'(10); host_wdata = 8'hAB; blk_start = 1;
      step();
      host_we = 0; blk_start = 0;
      peek(10, 8'hAB, "R11 host write wins");
      peek(11, 8'h2B, "R2 neighbour copied");

      host_we = 1; host_addr = AW'(30); host_wdata = 8'hEE;
      step();
      cfg_pair_mode = 1; host_addr = AW'(60);
      step();
      host_we = 0; cfg_pair_mode = 0;
      for (int i = 0; i < N; i++) peek(i, me[0][0][i], "R9 ignored write");

      for (int n = 0; n < 4000; n++) begin
         cfg_win_user  = 1'($urandom_range(0, 1));
         cfg_keep_head = ($urandom_range(0, 3) == 0);
         cfg_hold_de   = ($urandom_range(0, 3) == 0);
         cfg_hold_ef   = ($urandom_range(0, 3) == 0);
         cfg_pair_mode = 1'($urandom_range(0, 1));
         cfg_chan_b    = 1'($urandom_range(0, 1));
         blk_start     = ($urandom_range(0, 7) == 0);
         din_we        = ($urandom_range(0, 1) == 0);
         din_kind      = 1'($urandom_range(0, 1));
         din_chan      = 1'($urandom_range(0, 1));
         din_idx       = IW'($urandom_range(0, N - 1));
         din_byte      = 8'($urandom);
         host_we       = ($urandom_range(0, 3) == 0);
         host_addr     = AW'($urandom);
         host_wdata    = 8'($urandom);
         tx_kind       = 1'($urandom_range(0, 1));
         tx_chan       = 1'($urandom_range(0, 1));
         tx_idx        = IW'($urandom);
         step();
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule